// File: doc/BRIEF.md
# Lockable Watchdog Timer

This block is a watchdog that counts ticks of a slow clock enable and raises a one-cycle reset request when a chosen number of ticks passes without a restart. Software keeps the system alive by pulsing the restart input before the interval runs out. The count only moves on cycles where the slow tick input is high, so the system clock can run much faster than the time base.

Out of reset the watchdog is running with its longest interval. Software may pick a shorter interval or turn the watchdog off. It may also lock the watchdog. Once locked, the watchdog stays enabled and keeps its interval until the synchronous reset input is asserted again. The slow tick source and the chip-wide reset sequencing are outside this block.

Top module: `lockable_watchdog`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `bark_o` is 0. After reset the watchdog is enabled with interval code 7, so `bark_o` pulses after the 8192nd tick.
- R2: Interval code `sel_i` = k (3 bits, 0..7) sets the interval to 2^(6+k) ticks. `bark_o` goes high in the cycle after the clock edge that samples the last tick of the interval.
- R3: `bark_o` is high for exactly one cycle. The count then starts again from zero, so the next pulse comes one full interval later.
- R4: Cycles with `tick_i` low do not advance the count.
- R5: `kick_i` clears the count. If `kick_i` and `tick_i` are high in the same cycle, the clear wins and that tick is not counted.
- R6: An interval write that is accepted (`sel_wr_i` high while unlocked) also clears the count, so the new interval is timed from zero.
- R7: `dis_i` stops the watchdog and holds the count at zero. `en_i` starts it again from zero. While the watchdog is stopped, `bark_o` stays 0.
- R8: `lock_i` sets a sticky lock and also enables the watchdog. While the lock is set, and in the cycle where `lock_i` is itself high, `dis_i` and `sel_wr_i` are ignored.
- R9: Only `rst` clears the lock. After a reset, disables and interval writes take effect again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Slow time-base enable, one cycle per tick |
| kick_i | input | 1 | Restart strobe |
| sel_wr_i | input | 1 | Interval write strobe |
| sel_i | input | 3 | Interval code |
| dis_i | input | 1 | Disable command |
| en_i | input | 1 | Enable command |
| lock_i | input | 1 | Lock command |
| bark_o | output | 1 | Reset request, one-cycle pulse |

## Verification
Every command input is registered on the edge that samples it. The reset request register is loaded on that same edge, so `bark_o` answers a tick, restart, write or mode command one edge after the command is driven. The driver pushes one expected `bark_o` value for each cycle it drives. The monitor pops that value 1 ns after the following rising edge and compares it with the port. Expiries are therefore checked against the exact cycle: one tick early or one tick late is caught as a mismatch, not as a missing event.

// File: rtl/wd_pkg.sv
package wd_pkg;
  parameter int unsigned MIN_EXP = 6;
  parameter int unsigned SEL_W   = 3;
  localparam int unsigned NUM_SEL = 1 << SEL_W;
  localparam int unsigned MAX_EXP = MIN_EXP + NUM_SEL - 1;
  localparam int unsigned CNT_W   = MAX_EXP;
  typedef logic [SEL_W-1:0] sel_t;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/wd_cfg.sv
module wd_cfg
  import wd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sel_wr_i,
  input  sel_t sel_i,
  input  logic dis_i,
  input  logic en_i,
  input  logic lock_i,
  output logic run_o,
  output logic lock_o,
  output sel_t sel_o,
  output logic restart_o
);
  logic run_q, lock_q;
  sel_t sel_q;
  logic guarded;

  // a lock arriving in the same cycle already guards the settings
  assign guarded   = lock_q | lock_i;
  assign restart_o = sel_wr_i & ~guarded;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b1;
      lock_q <= 1'b0;
      sel_q  <= sel_t'(NUM_SEL - 1);
    end else begin
      if (lock_i) lock_q <= 1'b1;
      if (en_i || lock_i) run_q <= 1'b1;
      else if (dis_i && !guarded) run_q <= 1'b0;
      if (restart_o) sel_q <= sel_i;
    end
  end

  assign run_o  = run_q;
  assign lock_o = lock_q;
  assign sel_o  = sel_q;
endmodule

// File: rtl/wd_cnt.sv
module wd_cnt
  import wd_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic tick_i,
  input  logic clear_i,
  input  logic run_i,
  input  sel_t sel_i,
  output logic expire_o
);
  cnt_t last_tbl [NUM_SEL];
  cnt_t cnt_q;
  logic hit;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_last
    assign last_tbl[g] = cnt_t'((1 << (MIN_EXP + g)) - 1);
  end

  assign hit = (cnt_q == last_tbl[sel_i]);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      expire_o <= 1'b0;
    end else begin
      expire_o <= 1'b0;
      if (clear_i || !run_i) begin
        cnt_q <= '0;
      end else if (tick_i) begin
        if (hit) begin
          cnt_q    <= '0;
          expire_o <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/lockable_watchdog.sv
module lockable_watchdog
  import wd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             kick_i,
  input  logic             sel_wr_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             dis_i,
  input  logic             en_i,
  input  logic             lock_i,
  output logic             bark_o
);
  logic run_q, lock_q, restart;
  sel_t sel_q;

  wd_cfg u_cfg (
    .clk(clk), .rst(rst), .sel_wr_i(sel_wr_i), .sel_i(sel_i),
    .dis_i(dis_i), .en_i(en_i), .lock_i(lock_i),
    .run_o(run_q), .lock_o(lock_q), .sel_o(sel_q), .restart_o(restart)
  );

  wd_cnt u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .clear_i(kick_i | restart),
    .run_i(run_q), .sel_i(sel_q), .expire_o(bark_o)
  );
endmodule

// File: rtl/wd_chk.sv
module wd_chk (
  input logic clk,
  input logic rst,
  input logic tick_i,
  input logic kick_i,
  input logic lock_i,
  input logic run_i,
  input logic bark_o
);
  logic lock_seen;
  always_ff @(posedge clk) begin
    if (rst) lock_seen <= 1'b0;
    else if (lock_i) lock_seen <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !bark_o);
  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst) bark_o |=> !bark_o);
  // R4
  tick_needed_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick_i || kick_i) |=> !bark_o);
  // R7
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst) !run_i |=> !bark_o);
  // R8
  lock_keeps_run_chk: assert property (@(posedge clk) disable iff (rst) lock_seen |-> run_i);
endmodule

bind lockable_watchdog wd_chk u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
  .lock_i(lock_i), .run_i(run_q), .bark_o(bark_o)
);

// File: tb/lockable_watchdog_tb.sv
module lockable_watchdog_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_i = 0, kick_i = 0, sel_wr_i = 0, dis_i = 0, en_i = 0, lock_i = 0;
  logic [2:0] sel_i = 3'd0;
  logic bark_o;

  int total = 0, bad = 0;
  bit finished = 0;
  bit   exp_q [$];
  string req_q [$];

  always #2 clk = ~clk;

  lockable_watchdog u_dut (
    .clk(clk), .rst(rst), .tick_i(tick_i), .kick_i(kick_i),
    .sel_wr_i(sel_wr_i), .sel_i(sel_i), .dis_i(dis_i), .en_i(en_i),
    .lock_i(lock_i), .bark_o(bark_o)
  );

  // monitor: compares one expected value per driven cycle
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string r;
      e = exp_q.pop_front();
      r = req_q.pop_front();
      total++;
      if (bark_o !== e) begin
        bad++;
        $display("FAIL %s: bark_o=%b expected=%b at %0t", r, bark_o, e, $time);
      end
    end
  end

  task automatic step(input bit r, input bit t, input bit k, input bit w,
                      input logic [2:0] s, input bit d, input bit en,
                      input bit l, input bit e, input string req);
    @(negedge clk);
    rst = r; tick_i = t; kick_i = k; sel_wr_i = w; sel_i = s;
    dis_i = d; en_i = en; lock_i = l;
    exp_q.push_back(e);
    req_q.push_back(req);
  endtask

  task automatic ticks(input int n, input bit last_fires, input string req);
    for (int i = 0; i < n; i++)
      step(0, 1, 0, 0, 0, 0, 0, 0, last_fires && (i == n - 1), req);
  endtask

  task automatic idle(input string req);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, req);
  endtask

  initial begin
    // R1 reset and default longest interval
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R1");
    ticks(8192, 1, "R1");
    // R3 pulse width and wrap to a full second interval
    idle("R3");
    ticks(8192, 1, "R3");
    // R2 shortest interval, written while unlocked
    step(0, 0, 0, 1, 3'd0, 0, 0, 0, 0, "R2");
    ticks(64, 1, "R2");
    // R4 ticks every other cycle
    for (int i = 0; i < 64; i++) begin
      step(0, 1, 0, 0, 0, 0, 0, 0, i == 63, "R4");
      idle("R4");
    end
    // R5 kick with a tick in the same cycle
    ticks(63, 0, "R5");
    step(0, 1, 1, 0, 0, 0, 0, 0, 0, "R5");
    ticks(64, 1, "R5");
    // R6 interval write restarts the count
    ticks(60, 0, "R6");
    step(0, 1, 0, 1, 3'd1, 0, 0, 0, 0, "R6");
    ticks(128, 1, "R6");
    // R7 disable then enable
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R7");
    ticks(300, 0, "R7");
    step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R7");
    ticks(128, 1, "R7");
    // R8 lock, then disable and interval write ignored
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 3'd0, 0, 0, 0, 0, "R8");
    ticks(128, 1, "R8");
    // R9 reset clears the lock
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R9");
    step(0, 0, 0, 1, 3'd0, 0, 0, 0, 0, "R9");
    ticks(64, 1, "R9");
    step(0, 0, 0, 0, 0, 1, 0, 0, 0, "R9");
    ticks(100, 0, "R9");
    // R8 lock restarts a stopped watchdog
    step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R8");
    ticks(64, 1, "R8");
    // R8 lock in the same cycle as disable and write
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    step(0, 0, 0, 1, 3'd0, 1, 0, 1, 0, "R8");
    ticks(8192, 1, "R8");
    idle("R3");
    @(negedge clk);
    @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: run hung, actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule